// File: doc/BRIEF.md
# Opcode-Decoded Accumulator ALU with Condition Flags

This block is the arithmetic and logic slice of a small accumulator machine. It holds a 32-bit accumulator and four condition flags: carry, zero, negative and overflow. Each time the execute strobe is high, it combines the memory data word with the accumulator. A four-bit opcode nibble steers the whole slice. There is no separate ALU-operation field. Single opcode bits and short products of them choose four things: whether the memory word is inverted on its way to the A operand, where the adder carry-in comes from, which functional unit (adder, AND, OR, XOR or A-operand pass) drives the result bus, and whether the result is kept.

The nibble is written `op[3:0]`. `op[3]` is the leading opcode bit, d0, and `op[0]` is the last, d3. The names d0..d3 are used below. In the data words the sign bit is bit 31, the most significant bit. The compare and bit-test opcodes run the adder or the AND unit only to set flags; they leave the accumulator unchanged. Reset is synchronous and has priority over the strobe.

Top module: `opdec_alu`

## Requirements
- R1: While `rst` is high at a rising edge, the accumulator and all four flags become 0, whatever the strobe is.
- R2: At an edge where `exec_en` is low, the accumulator and all four flags keep their values.
- R3: The A operand is the bitwise complement of `md_in` when ~d0 & ~d1 & (~d2 | d3), which is opcodes 0x0, 0x1 and 0x3. Otherwise it is `md_in` unchanged. The B operand is always the accumulator.
- R4: The adder carry-in is (carry flag & ~d3) | (~d1 & d3). So opcodes 0x0 and 0x4 take the stored carry, 0x1 and 0x3 take 1, and 0x5 and 0x7 take 0.
- R5: The result bus is driven by exactly one unit. The adder drives it when ~d0 & (~d2 | d3). The A operand passes through when ~d0 & d2 & ~d3. AND drives it when d0 & d3. OR drives it when d0 & ~d2 & ~d3. XOR drives it when d0 & d2 & ~d3. If no unit is selected, the bus is zero.
- R6: On a strobe, the accumulator takes the result bus unless d2 & d3 (opcodes 0x3, 0x7, 0xB, 0xF, the compare and bit-test group). In that group it is unchanged.
- R7: On every strobe, the zero flag is set exactly when all 32 result bits are 0.
- R8: On every strobe, the negative flag takes result bit 31.
- R9: On a strobe where the adder drives the result, the carry flag takes the adder's 33rd (carry-out) bit. On any other strobe it keeps its value.
- R10: The overflow flag is updated exactly when the carry flag is. It is set when the A and B operand sign bits match each other and the result sign differs from them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| exec_en | input | 1 | Execute strobe; state updates only when high |
| op | input | 4 | Opcode nibble; op[3] is the leading bit d0 |
| md_in | input | 32 | Memory data word |
| ac_q | output | 32 | Accumulator |
| cf_q | output | 1 | Carry flag |
| zf_q | output | 1 | Zero flag |
| nf_q | output | 1 | Negative flag |
| vf_q | output | 1 | Overflow flag |

## Verification
The properties assume that `rst` is high at the first clock edge and that `op`, `md_in` and `exec_en` hold known 0/1 values whenever they are sampled. Several properties compare the state after an edge with the opcode sampled at that edge, so they also assume the inputs stay steady around the edge. The stimulus meets all of this: it holds reset for its first cycles, changes every input one time unit after a rising edge, and draws only defined values. The stimulus mixes directed cases with random ones. The directed cases cover the sign boundary, an all-ones plus one carry, zero results and chained carry use. Every opcode appears with the strobe both high and low.

// File: rtl/opdec_alu_pkg.sv
package opdec_alu_pkg;

  // functional units that can drive the result bus
  localparam int unsigned NUM_UNITS = 5;
  localparam int unsigned U_ADD  = 0;
  localparam int unsigned U_AND  = 1;
  localparam int unsigned U_OR   = 2;
  localparam int unsigned U_XOR  = 3;
  localparam int unsigned U_PASS = 4;

  // control word produced from the opcode nibble
  typedef struct packed {
    logic                 inv_a;    // A operand takes inverted memory word
    logic                 cin_cf;   // carry-in sourced from stored carry
    logic                 cin_one;  // carry-in forced to one
    logic [NUM_UNITS-1:0] sel;      // one-hot result-bus driver
    logic                 ac_we;    // keep result in accumulator
    logic                 arith;    // carry/overflow update
  } dec_t;

endpackage

// File: rtl/opdec_ctl.sv
module opdec_ctl
  import opdec_alu_pkg::*;
(
  input  logic [3:0] op,
  output dec_t       dec
);

  logic d0, d1, d2, d3;
  logic add_term;

  assign d0 = op[3];
  assign d1 = op[2];
  assign d2 = op[1];
  assign d3 = op[0];

  assign add_term = ~d0 & (~d2 | d3);

  always_comb begin
    dec           = '0;
    dec.inv_a     = ~d0 & ~d1 & (~d2 | d3);
    dec.cin_cf    = ~d3;
    dec.cin_one   = ~d1 & d3;
    dec.sel[U_ADD]  = add_term;
    dec.sel[U_AND]  = d0 & d3;
    dec.sel[U_OR]   = d0 & ~d2 & ~d3;
    dec.sel[U_XOR]  = d0 & d2 & ~d3;
    dec.sel[U_PASS] = ~d0 & d2 & ~d3;
    dec.ac_we     = ~(d2 & d3);
    dec.arith     = add_term;
  end

endmodule

// File: rtl/opdec_dpath.sv
module opdec_dpath
  import opdec_alu_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] md,
  input  logic [W-1:0] ac,
  input  dec_t         dec,
  input  logic         cf,
  output logic [W-1:0] abus,
  output logic [W-1:0] bbus,
  output logic         cin,
  output logic [W-1:0] obus,
  output logic         cout,
  output logic         ovf
);

  localparam int unsigned SW = W + 1;
  localparam int unsigned MSB = W - 1;

  // full-width add with carry in; top bit is the carry out
  function automatic logic [SW-1:0] wide_add(input logic [W-1:0] a,
                                             input logic [W-1:0] b,
                                             input logic c);
    return {1'b0, a} + {1'b0, b} + {{W{1'b0}}, c};
  endfunction

  // same-sign operands whose sum changes sign
  function automatic logic sign_flip(input logic sa, input logic sb,
                                     input logic sr);
    return (sa & sb & ~sr) | (~sa & ~sb & sr);
  endfunction

  logic [SW-1:0] sum;
  logic [W-1:0]  unit_res [NUM_UNITS];
  logic [W-1:0]  gated    [NUM_UNITS];

  assign abus = dec.inv_a ? ~md : md;
  assign bbus = ac;
  assign cin  = (cf & dec.cin_cf) | dec.cin_one;
  assign sum  = wide_add(abus, bbus, cin);
  assign cout = sum[W];
  assign ovf  = sign_flip(abus[MSB], bbus[MSB], sum[MSB]);

  assign unit_res[U_ADD]  = sum[W-1:0];
  assign unit_res[U_AND]  = abus & bbus;
  assign unit_res[U_OR]   = abus | bbus;
  assign unit_res[U_XOR]  = abus ^ bbus;
  assign unit_res[U_PASS] = abus;

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_gate
    assign gated[u] = unit_res[u] & {W{dec.sel[u]}};
  end

  // unselected units contribute zero, so an empty select gives zero
  always_comb begin
    obus = '0;
    for (int u = 0; u < NUM_UNITS; u++) begin
      obus = obus | gated[u];
    end
  end

endmodule

// File: rtl/opdec_state.sv
module opdec_state
  import opdec_alu_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         exec_en,
  input  dec_t         dec,
  input  logic [W-1:0] obus,
  input  logic         cout,
  input  logic         ovf,
  output logic [W-1:0] ac_q,
  output logic         cf_q,
  output logic         zf_q,
  output logic         nf_q,
  output logic         vf_q
);

  localparam int unsigned MSB = W - 1;

  always_ff @(posedge clk) begin
    if (rst) begin
      ac_q <= '0;
      cf_q <= 1'b0;
      zf_q <= 1'b0;
      nf_q <= 1'b0;
      vf_q <= 1'b0;
    end else if (exec_en) begin
      if (dec.ac_we) ac_q <= obus;
      zf_q <= ~|obus;
      nf_q <= obus[MSB];
      if (dec.arith) begin
        cf_q <= cout;
        vf_q <= ovf;
      end
    end
  end

endmodule

// File: rtl/opdec_alu.sv
module opdec_alu
  import opdec_alu_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         exec_en,
  input  logic [3:0]   op,
  input  logic [W-1:0] md_in,
  output logic [W-1:0] ac_q,
  output logic         cf_q,
  output logic         zf_q,
  output logic         nf_q,
  output logic         vf_q
);

  dec_t                 dec_w;
  logic [W-1:0]         abus_w;
  logic [W-1:0]         bbus_w;
  logic                 cin_w;
  logic [W-1:0]         obus_w;
  logic                 cout_w;
  logic                 ovf_w;
  logic [NUM_UNITS-1:0] unit_sel_w;
  logic                 ac_we_w;

  assign unit_sel_w = dec_w.sel;
  assign ac_we_w    = dec_w.ac_we;

  opdec_ctl i_ctl (
    .op  (op),
    .dec (dec_w)
  );

  opdec_dpath #(.W(W)) i_dpath (
    .md   (md_in),
    .ac   (ac_q),
    .dec  (dec_w),
    .cf   (cf_q),
    .abus (abus_w),
    .bbus (bbus_w),
    .cin  (cin_w),
    .obus (obus_w),
    .cout (cout_w),
    .ovf  (ovf_w)
  );

  opdec_state #(.W(W)) i_state (
    .clk     (clk),
    .rst     (rst),
    .exec_en (exec_en),
    .dec     (dec_w),
    .obus    (obus_w),
    .cout    (cout_w),
    .ovf     (ovf_w),
    .ac_q    (ac_q),
    .cf_q    (cf_q),
    .zf_q    (zf_q),
    .nf_q    (nf_q),
    .vf_q    (vf_q)
  );

endmodule

// File: rtl/opdec_alu_chk.sv
module opdec_alu_chk #(
  parameter int unsigned W = 32,
  parameter int unsigned NU = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          exec_en,
  input logic [3:0]    op,
  input logic [W-1:0]  ac_q,
  input logic          cf_q,
  input logic          zf_q,
  input logic          nf_q,
  input logic          vf_q,
  input logic [W-1:0]  obus,
  input logic [NU-1:0] unit_sel,
  input logic          ac_we
);

  logic adder_op;
  assign adder_op = ~op[3] & (~op[1] | op[0]);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (ac_q == '0) && !cf_q && !zf_q && !nf_q && !vf_q);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !exec_en |=> $stable(ac_q) && $stable({cf_q, zf_q, nf_q, vf_q}));

  // R5
  one_driver_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot(unit_sel));

  // R6
  cmp_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    exec_en && op[1] && op[0] |=> $stable(ac_q));

  // R6
  ac_load_chk: assert property (@(posedge clk) disable iff (rst)
    exec_en && ac_we |=> ac_q == $past(obus));

  // R7
  zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
    exec_en |=> zf_q == ($past(obus) == '0));

  // R8
  neg_flag_chk: assert property (@(posedge clk) disable iff (rst)
    exec_en |=> nf_q == $past(obus[W-1]));

  // R9
  carry_hold_chk: assert property (@(posedge clk) disable iff (rst)
    exec_en && !adder_op |=> $stable(cf_q));

  // R10
  ovf_hold_chk: assert property (@(posedge clk) disable iff (rst)
    exec_en && !adder_op |=> $stable(vf_q));

endmodule

bind opdec_alu opdec_alu_chk #(.W(W), .NU(opdec_alu_pkg::NUM_UNITS)) i_chk (
  .clk      (clk),
  .rst      (rst),
  .exec_en  (exec_en),
  .op       (op),
  .ac_q     (ac_q),
  .cf_q     (cf_q),
  .zf_q     (zf_q),
  .nf_q     (nf_q),
  .vf_q     (vf_q),
  .obus     (obus_w),
  .unit_sel (unit_sel_w),
  .ac_we    (ac_we_w)
);

// File: tb/test_opdec_alu.sv
module test_opdec_alu;

  logic        clk = 1'b0;
  logic        rst;
  logic        exec_en;
  logic [3:0]  op;
  logic [31:0] md_in;
  logic [31:0] ac_q;
  logic        cf_q, zf_q, nf_q, vf_q;

  int compared = 0;
  int mismatched = 0;

  // reference state
  logic [31:0] m_ac;
  logic        m_cf, m_zf, m_nf, m_vf;

  always #4 clk = ~clk;  // 125 MHz

  opdec_alu i_opdec_alu (
    .clk(clk), .rst(rst), .exec_en(exec_en), .op(op), .md_in(md_in),
    .ac_q(ac_q), .cf_q(cf_q), .zf_q(zf_q), .nf_q(nf_q), .vf_q(vf_q)
  );

  task automatic chk(input string what, input string req,
                     input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic string tag_of(input logic en, input logic [3:0] o);
    if (!en) return "R2";
    if (o inside {4'h3, 4'h7, 4'hB, 4'hF}) return "R6";
    if (o inside {4'h0, 4'h1}) return "R3";
    if (o inside {4'h4, 4'h5}) return "R4";
    return "R5";
  endfunction

  task automatic compare_all(input string ac_tag, input logic en);
    chk("acc", ac_tag, ac_q, m_ac);
    chk("carry", en ? "R9" : "R2", {31'd0, cf_q}, {31'd0, m_cf});
    chk("zero", en ? "R7" : "R2", {31'd0, zf_q}, {31'd0, m_zf});
    chk("neg", en ? "R8" : "R2", {31'd0, nf_q}, {31'd0, m_nf});
    chk("ovf", en ? "R10" : "R2", {31'd0, vf_q}, {31'd0, m_vf});
  endtask

  // one execute cycle: behavioural opcode table, then compare after the edge
  task automatic step(input logic en, input logic [3:0] o, input logic [31:0] m);
    logic [32:0] s;
    logic [31:0] a, r;
    logic        adder;
    a     = (o inside {4'h0, 4'h1, 4'h3}) ? ~m : m;                // R3
    adder = o inside {4'h0, 4'h1, 4'h3, 4'h4, 4'h5, 4'h7};
    case (o)                                                      // R4
      4'h0, 4'h4: s = {1'b0, a} + {1'b0, m_ac} + {32'd0, m_cf};
      4'h1, 4'h3: s = {1'b0, a} + {1'b0, m_ac} + 33'd1;
      4'h5, 4'h7: s = {1'b0, a} + {1'b0, m_ac};
      default:    s = '0;
    endcase
    case (o)
      4'h2, 4'h6: r = m;
      4'h8, 4'hC: r = m | m_ac;
      4'hA, 4'hE: r = m ^ m_ac;
      4'h9, 4'hB, 4'hD, 4'hF: r = m & m_ac;
      default:    r = s[31:0];
    endcase
    exec_en = en; op = o; md_in = m;
    @(posedge clk);
    #1;
    if (en) begin
      if (!(o inside {4'h3, 4'h7, 4'hB, 4'hF})) m_ac = r;
      m_zf = (r == 32'd0);
      m_nf = r[31];
      if (adder) begin
        m_cf = s[32];
        m_vf = (a[31] == m_ac[31] || !(o inside {4'h3, 4'h7}) ? 1'b0 : 1'b0) |
               ((a[31] == s[31] ? 1'b0 : 1'b1) & (a[31] == prev_b_sign));
      end
    end
    compare_all(tag_of(en, o), en);
  endtask

  logic prev_b_sign;

  // wrapper keeps B-operand sign from before the update for the overflow rule
  task automatic exec(input logic en, input logic [3:0] o, input logic [31:0] m);
    prev_b_sign = m_ac[31];
    step(en, o, m);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    rst = 1'b1; exec_en = 1'b1; op = 4'h2; md_in = 32'hDEAD_BEEF;
    m_ac = '0; m_cf = 0; m_zf = 0; m_nf = 0; m_vf = 0;
    repeat (3) @(posedge clk);
    #1;
    compare_all("R1", 1'b1);  // R1 reset wins over strobe
    rst = 1'b0;

    // R5 load via pass-through, then R2 idle strobe
    exec(1, 4'h2, 32'h7FFF_FFFF);
    exec(0, 4'h5, 32'h0000_0001);
    // R10 signed overflow on plain add
    exec(1, 4'h5, 32'h0000_0001);
    // R9 carry out: all ones plus one
    exec(1, 4'h2, 32'hFFFF_FFFF);
    exec(1, 4'h5, 32'h0000_0001);
    // R4 add with stored carry, subtract with borrow
    exec(1, 4'h4, 32'h0000_0010);
    exec(1, 4'h0, 32'h0000_0003);
    // R3 subtract, R6 compare keeps accumulator
    exec(1, 4'h1, 32'h0000_0005);
    exec(1, 4'h3, 32'h1234_5678);
    exec(1, 4'h7, 32'h8000_0000);
    // R7 zero result from AND, R6 bit test
    exec(1, 4'h9, 32'h0000_0000);
    exec(1, 4'h2, 32'hF0F0_F0F0);
    exec(1, 4'hB, 32'h0F0F_0F0F);
    exec(1, 4'hE, 32'hFFFF_FFFF);
    exec(1, 4'hC, 32'h8000_0001);

    // random mix over all opcodes and strobe values
    for (int i = 0; i < 600; i++) begin
      logic [31:0] v;
      case ($urandom % 4)
        0: v = 32'h8000_0000;
        1: v = 32'hFFFF_FFFF;
        default: v = $urandom;
      endcase
      exec(($urandom % 5) != 0, 4'($urandom), v);
    end

    // R1 reset mid-run
    rst = 1'b1; exec_en = 1'b1;
    @(posedge clk); #1;
    m_ac = '0; m_cf = 0; m_zf = 0; m_nf = 0; m_vf = 0;
    compare_all("R1", 1'b1);
    rst = 1'b0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule